// File: doc/BRIEF.md
# Serial Audio Port (Stereo and TDM, Slave)

This block is the slave side of a serial audio link. An external master drives a bit clock and a frame clock. The block samples both clocks, and the serial data input, into its own system clock domain. From that it tracks where each frame starts and which slot and bit are on the line. It gathers one left/right pair of received samples and serializes one pair of local samples onto the data output.

Each frame holds 2, 4 or 8 equal slots. The frame length, the MSB delay within a slot, the clock polarities and the slot pair used in each direction are set from static configuration inputs. A configuration that cannot work raises an error flag. While the flag is set, the block stays silent.

Top module: `sap_port`

## Requirements
- R1: After a synchronous active-low reset, `rx_valid`, `rx_left`, `rx_right` and `sdata_out` are all zero.
- R2: With `cfg_frm_inv`=0 a frame starts at the first sampling bit-clock edge that sees the frame clock low after it was high at the previous sampling edge; with `cfg_frm_inv`=1 the frame clock levels are inverted. With `cfg_bclk_inv`=0 input data is sampled at rising bit-clock edges and output data changes after falling edges; with 1 the edges swap.
- R3: `cfg_chans` selects 2 slots (0), 4 slots (1) or 8 slots (2). `cfg_frame_len` selects 32 (0), 48 (1), 64 (2), 128 (3) or 256 (4) bit clocks per frame. Each slot is the frame length divided by the slot count. Slot k starts at bit k times the slot length, counting the first bit of the frame as bit 0.
- R4: `cfg_msb_dly` places the MSB of every slot 0 (code 0), 1 (code 1) or 8 (code 2) bit clocks after the slot start.
- R5: The word length `cfg_wlen` is 16 to 24 bits, sent MSB first in two's complement. Received words appear MSB-aligned in the 24-bit outputs, with the unused low bits zero.
- R6: The received pair is taken from slot 2p (left) and slot 2p+1 (right), where p = `cfg_rx_pair`. Data bits in all other slots, and non-data bits, are ignored.
- R7: `rx_valid` is a one-cycle pulse that comes a few system clocks after the last data bit of the right receive slot. `rx_left` and `rx_right` change only with that pulse, exactly once per frame.
- R8: `tx_left` and `tx_right` are captured at each frame start. They are sent MSB first in slot 2q (left) and slot 2q+1 (right), where q = `cfg_tx_pair`.
- R9: Every output bit that is not a data bit of the transmit pair is zero, and `sdata_out` changes only in the cycle after a detected output edge or under the error flag.
- R10: `cfg_err` is high when any of these holds: a code is unused, the word length is outside 16 to 24, MSB delay plus word length exceeds the slot length, or either pair index is not below the slot count over two. While `cfg_err` is high, `rx_valid` stays low and `sdata_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Bit clock from the master |
| lrclk_in | input | 1 | Frame clock from the master |
| sdata_in | input | 1 | Serial data into the port |
| cfg_chans | input | 2 | Slot count code (R3) |
| cfg_frame_len | input | 3 | Bit clocks per frame code (R3) |
| cfg_msb_dly | input | 2 | MSB delay code (R4) |
| cfg_wlen | input | 5 | Word length in bits (R5) |
| cfg_bclk_inv | input | 1 | Bit clock polarity (R2) |
| cfg_frm_inv | input | 1 | Frame clock polarity (R2) |
| cfg_rx_pair | input | 2 | Receive slot pair index (R6) |
| cfg_tx_pair | input | 2 | Transmit slot pair index (R8) |
| tx_left | input | 24 | Left word to send, MSB-aligned |
| tx_right | input | 24 | Right word to send, MSB-aligned |
| sdata_out | output | 1 | Serial data out of the port |
| rx_left | output | 24 | Received left word, MSB-aligned |
| rx_right | output | 24 | Received right word, MSB-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |
| cfg_err | output | 1 | Configuration cannot be used |

## Verification
The bench fills every non-data bit and every unselected slot with random noise. A design that picked the wrong slot, or dropped the MSB delay, would return corrupted words. One that masked the wrong low bits at 16 or 20 bits would do the same. The tightest fits are exercised: an 8-bit delay with a 24-bit word filling a 32-clock slot exactly, a right slot whose last data bit is the last bit of the frame, and a 48-clock frame split into uneven-looking 12-clock slots. Any off-by-one in the slot arithmetic shows up there as a missing strobe or a shifted word. Configurations that are one bit too tight, or that name a pair out of range, must raise the error flag and keep the output line at zero. Both clock polarities are inverted together, so a design that framed on the wrong edge would lose whole frames.

// File: rtl/sap_pkg.sv
// Shared constants and encodings for the serial audio port.
// Assumes frame lengths of at most 256 bit clocks and at most 8 slots.
package sap_pkg;
    localparam int unsigned FRAME_W = 9;               // holds up to 256
    localparam int unsigned OFF_W   = FRAME_W - 1;     // slot length at most 128
    localparam int unsigned SLOT_W  = 4;               // 8 slots plus an idle code
    localparam logic [SLOT_W-1:0] SLOT_IDLE = '1;

    typedef enum logic [1:0] {
        CH_STEREO = 2'd0,
        CH_TDM4   = 2'd1,
        CH_TDM8   = 2'd2
    } chan_mode_e;
endpackage

// File: rtl/sap_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes inputs are slow relative to clk, so the bits need no coherency.
module sap_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the raw levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sap_cfg.sv
// Decodes the static configuration into slot length and MSB delay, and
// flags any combination that cannot carry a word in its slot.
// Assumes the configuration is changed only while the line is idle.
module sap_cfg import sap_pkg::*; #(
    parameter int unsigned SMP_W = 24,
    parameter int unsigned MIN_W = 16,
    localparam int unsigned WL_W = $clog2(SMP_W + 1)
) (
    input  logic [1:0]      chans,
    input  logic [2:0]      frame_code,
    input  logic [1:0]      dly_code,
    input  logic [WL_W-1:0] wlen,
    input  logic [1:0]      rx_pair,
    input  logic [1:0]      tx_pair,
    output logic [OFF_W-1:0] slot_len,
    output logic [3:0]      dly,
    output logic            err
);
    logic [FRAME_W-1:0] frame_bits;
    logic [FRAME_W-1:0] slot_full;
    logic [2:0]         pairs;
    logic               dly_bad;
    logic [FRAME_W:0]   need;

    // Translate the frame length code to a bit count.
    always_comb begin
        case (frame_code)
            3'd0:    frame_bits = FRAME_W'(32);
            3'd1:    frame_bits = FRAME_W'(48);
            3'd2:    frame_bits = FRAME_W'(64);
            3'd3:    frame_bits = FRAME_W'(128);
            3'd4:    frame_bits = FRAME_W'(256);
            default: frame_bits = '0;
        endcase
    end

    // Translate the delay code to a bit count.
    always_comb begin
        dly_bad = 1'b0;
        case (dly_code)
            2'd0:    dly = 4'd0;
            2'd1:    dly = 4'd1;
            2'd2:    dly = 4'd8;
            default: begin dly = 4'd0; dly_bad = 1'b1; end
        endcase
    end

    // Slot count is a power of two, so the slot length is a shift.
    always_comb begin
        slot_full = frame_bits >> ({1'b0, chans} + 3'd1);
        pairs     = 3'd1 << chans;
        need      = (FRAME_W+1)'(dly) + (FRAME_W+1)'(wlen);
    end

    assign slot_len = slot_full[OFF_W-1:0];

    // Combine every reason the configuration cannot work.
    assign err = (frame_bits == '0) || (chans == 2'd3) || dly_bad
              || (wlen < WL_W'(MIN_W)) || (wlen > WL_W'(SMP_W))
              || (need > {1'b0, slot_full})
              || ({1'b0, rx_pair} >= pairs) || ({1'b0, tx_pair} >= pairs);
endmodule

// File: rtl/sap_slot_track.sv
// Tracks slot index and bit offset within the slot, advancing once per
// step and restarting at a frame start. Idle until the first frame start;
// the slot index saturates at the idle code if frames run long.
module sap_slot_track import sap_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             start,
    input  logic [OFF_W-1:0] slot_len,
    output logic [SLOT_W-1:0] slot,
    output logic [OFF_W-1:0]  off
);
    // Advance the position on each step, wrapping the offset at slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= SLOT_IDLE;
            off  <= '0;
        end else if (step) begin
            if (start) begin
                slot <= '0;
                off  <= '0;
            end else if (off >= slot_len - OFF_W'(1)) begin
                off  <= '0;
                slot <= (slot == SLOT_IDLE) ? SLOT_IDLE : slot + SLOT_W'(1);
            end else begin
                off  <= off + OFF_W'(1);
            end
        end
    end
endmodule

// File: rtl/sap_port.sv
// Slave serial audio port. Samples bit clock, frame clock and data into
// the system clock domain, receives one slot pair and sends one slot pair.
// Assumes the system clock runs at least 8x the bit clock and the
// configuration is static while frames run.
module sap_port import sap_pkg::*; #(
    parameter int unsigned SMP_W       = 24,
    parameter int unsigned MIN_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bclk_in,
    input  logic                         lrclk_in,
    input  logic                         sdata_in,
    input  logic [1:0]                   cfg_chans,
    input  logic [2:0]                   cfg_frame_len,
    input  logic [1:0]                   cfg_msb_dly,
    input  logic [$clog2(SMP_W+1)-1:0]   cfg_wlen,
    input  logic                         cfg_bclk_inv,
    input  logic                         cfg_frm_inv,
    input  logic [1:0]                   cfg_rx_pair,
    input  logic [1:0]                   cfg_tx_pair,
    input  logic [SMP_W-1:0]             tx_left,
    input  logic [SMP_W-1:0]             tx_right,
    output logic                         sdata_out,
    output logic [SMP_W-1:0]             rx_left,
    output logic [SMP_W-1:0]             rx_right,
    output logic                         rx_valid,
    output logic                         cfg_err
);
    localparam int unsigned WL_W = $clog2(SMP_W + 1);
    localparam int unsigned SH_W = $clog2(SMP_W);

    logic [2:0]        sync_q;
    logic              bclk_c, lr_c, bclk_prev;
    logic              smp, drv, smp_d, drv_d, sd_q;
    logic              lr_smp_prev, lr_drv_prev, rx_start, tx_start;
    logic [OFF_W-1:0]  slot_len;
    logic [3:0]        dly;
    logic [SLOT_W-1:0] rx_slot, tx_slot;
    logic [OFF_W-1:0]  rx_off, tx_off, rx_rel, tx_rel;
    logic              rx_in_word, rx_last, rx_is_l, rx_is_r;
    logic              tx_in_word, tx_is_l, tx_is_r, tx_bit;
    logic [SMP_W-1:0]  sh, rx_nsh, rx_aligned, hold_l;
    logic [SMP_W-1:0]  txl_q, txr_q, tx_sel, tx_shift;

    sap_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sdata_in, lrclk_in, bclk_in}), .q(sync_q)
    );

    sap_cfg #(.SMP_W(SMP_W), .MIN_W(MIN_W)) u_cfg (
        .chans(cfg_chans), .frame_code(cfg_frame_len), .dly_code(cfg_msb_dly),
        .wlen(cfg_wlen), .rx_pair(cfg_rx_pair), .tx_pair(cfg_tx_pair),
        .slot_len(slot_len), .dly(dly), .err(cfg_err)
    );

    assign bclk_c = sync_q[0] ^ cfg_bclk_inv;
    assign lr_c   = sync_q[1] ^ cfg_frm_inv;
    assign smp    = bclk_c & ~bclk_prev;
    assign drv    = ~bclk_c & bclk_prev;
    assign rx_start = smp & lr_smp_prev & ~lr_c;
    assign tx_start = drv & lr_drv_prev & ~lr_c;

    // Edge history, sampled data and per-edge frame clock levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_prev   <= 1'b0;
            smp_d       <= 1'b0;
            drv_d       <= 1'b0;
            sd_q        <= 1'b0;
            lr_smp_prev <= 1'b0;
            lr_drv_prev <= 1'b0;
        end else begin
            bclk_prev <= bclk_c;
            smp_d     <= smp;
            drv_d     <= drv;
            if (smp) begin
                sd_q        <= sync_q[2];
                lr_smp_prev <= lr_c;
            end
            if (drv) lr_drv_prev <= lr_c;
        end
    end

    sap_slot_track u_rx_trk (
        .clk(clk), .rst_n(rst_n), .step(smp), .start(rx_start),
        .slot_len(slot_len), .slot(rx_slot), .off(rx_off)
    );

    sap_slot_track u_tx_trk (
        .clk(clk), .rst_n(rst_n), .step(drv), .start(tx_start),
        .slot_len(slot_len), .slot(tx_slot), .off(tx_off)
    );

    // Receive side: locate the current bit within the receive pair.
    always_comb begin
        rx_rel     = rx_off - OFF_W'(dly);
        rx_in_word = (rx_off >= OFF_W'(dly)) && (rx_rel < OFF_W'(cfg_wlen));
        rx_last    = rx_in_word && (rx_rel == OFF_W'(cfg_wlen) - OFF_W'(1));
        rx_is_l    = rx_slot == {1'b0, cfg_rx_pair, 1'b0};
        rx_is_r    = rx_slot == {1'b0, cfg_rx_pair, 1'b1};
        rx_nsh     = (rx_rel == '0) ? {{(SMP_W-1){1'b0}}, sd_q}
                                    : {sh[SMP_W-2:0], sd_q};
        rx_aligned = rx_nsh << (WL_W'(SMP_W) - cfg_wlen);
    end

    // Shift in data bits of the receive pair and publish at the right word end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            hold_l   <= '0;
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (smp_d && rx_in_word && (rx_is_l || rx_is_r)) begin
                sh <= rx_nsh;
                if (rx_last && rx_is_l) hold_l <= rx_aligned;
                if (rx_last && rx_is_r && !cfg_err) begin
                    rx_left  <= hold_l;
                    rx_right <= rx_aligned;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // Transmit side: pick the bit for the current position of the send pair.
    always_comb begin
        tx_rel     = tx_off - OFF_W'(dly);
        tx_in_word = (tx_off >= OFF_W'(dly)) && (tx_rel < OFF_W'(cfg_wlen));
        tx_is_l    = tx_slot == {1'b0, cfg_tx_pair, 1'b0};
        tx_is_r    = tx_slot == {1'b0, cfg_tx_pair, 1'b1};
        tx_sel     = tx_is_l ? txl_q : txr_q;
        tx_shift   = tx_sel << tx_rel[SH_W-1:0];
        tx_bit     = (tx_is_l || tx_is_r) && tx_in_word && tx_shift[SMP_W-1];
    end

    // Capture the words to send at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txl_q <= '0;
            txr_q <= '0;
        end else if (tx_start) begin
            txl_q <= tx_left;
            txr_q <= tx_right;
        end
    end

    // Drive the output line after each output edge; silent under error.
    always_ff @(posedge clk) begin
        if (!rst_n)       sdata_out <= 1'b0;
        else if (cfg_err) sdata_out <= 1'b0;
        else if (drv_d)   sdata_out <= tx_bit;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !rx_valid); // R10
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !sdata_out); // R10
    AST_SDOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_d && !cfg_err) |=> $stable(sdata_out)); // R9
    AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_right) || $past(rx_valid) == 1'b0); // R7
endmodule

// File: tb/test_sap_port.sv
module test_sap_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int SW         = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk_in = 1'b1, lrclk_in = 1'b1, sdata_in = 1'b0;
    logic [1:0] cfg_chans = 0, cfg_msb_dly = 0, cfg_rx_pair = 0, cfg_tx_pair = 0;
    logic [2:0] cfg_frame_len = 0;
    logic [4:0] cfg_wlen = 16;
    logic cfg_bclk_inv = 0, cfg_frm_inv = 0;
    logic [SW-1:0] tx_left = 0, tx_right = 0;
    logic sdata_out, rx_valid, cfg_err;
    logic [SW-1:0] rx_left, rx_right;

    int n_tests = 0, n_fail = 0, vcnt = 0;
    logic [SW-1:0] cap_l, cap_r;
    bit done = 0;

    sap_port i_sap_port (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .sdata_in(sdata_in), .cfg_chans(cfg_chans), .cfg_frame_len(cfg_frame_len),
        .cfg_msb_dly(cfg_msb_dly), .cfg_wlen(cfg_wlen), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_frm_inv(cfg_frm_inv), .cfg_rx_pair(cfg_rx_pair), .cfg_tx_pair(cfg_tx_pair),
        .tx_left(tx_left), .tx_right(tx_right), .sdata_out(sdata_out),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic int frame_bits(input int code);
        case (code)
            0: return 32; 1: return 48; 2: return 64; 3: return 128; 4: return 256;
            default: return 0;
        endcase
    endfunction

    function automatic int dly_bits(input int code);
        return (code == 0) ? 0 : (code == 1) ? 1 : 8;
    endfunction

    function automatic bit cfg_bad(input int ch, input int fc, input int dc,
                                   input int wl, input int rp, input int tp);
        int fb = frame_bits(fc);
        if (fb == 0 || ch == 3 || dc == 3 || wl < 16 || wl > 24) return 1;
        if (dly_bits(dc) + wl > (fb >> (ch + 1))) return 1;
        if (rp >= (1 << ch) || tp >= (1 << ch)) return 1;
        return 0;
    endfunction

    // Collect received strobes away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                vcnt++;
                cap_l = rx_left;
                cap_r = rx_right;
            end
        end
    end

    // One bit period: output edge first, then the sampling edge.
    task automatic send_bit(input logic lr_c, input logic sd, output logic sdo);
        @(negedge clk);
        bclk_in  = 1'b0 ^ cfg_bclk_inv;
        lrclk_in = lr_c ^ cfg_frm_inv;
        sdata_in = sd;
        repeat (HALF) @(negedge clk);
        sdo = sdata_out;
        bclk_in = 1'b1 ^ cfg_bclk_inv;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_frame(input bit bad);
        logic [SW-1:0] slot_w [8];
        logic [SW-1:0] wl_t, wr_t, mask, exp_l, exp_r;
        int n, slen, d, wl, s, o, mism;
        logic sd, expo, sdo, first_act, first_exp;
        n    = frame_bits(int'(cfg_frame_len));
        slen = n >> (int'(cfg_chans) + 1);
        d    = dly_bits(int'(cfg_msb_dly));
        wl   = int'(cfg_wlen);
        for (int k = 0; k < 8; k++) slot_w[k] = SW'($urandom);
        wl_t = SW'($urandom); wr_t = SW'($urandom);
        tx_left = wl_t; tx_right = wr_t;
        vcnt = 0; mism = 0; first_act = 0; first_exp = 0;
        for (int i = 0; i < n; i++) begin
            s = i / slen; o = i % slen;
            if (o >= d && o - d < wl) sd = slot_w[s][SW-1-(o-d)];
            else sd = 1'($urandom);
            expo = 1'b0;
            if (!bad && o >= d && o - d < wl) begin
                if (s == 2*int'(cfg_tx_pair))   expo = wl_t[SW-1-(o-d)];
                if (s == 2*int'(cfg_tx_pair)+1) expo = wr_t[SW-1-(o-d)];
            end
            send_bit(i >= n/2, sd, sdo);
            if (sdo !== expo) begin
                if (mism == 0) begin first_act = sdo; first_exp = expo; end
                mism++;
            end
        end
        repeat (4) @(negedge clk);
        mask  = ~((SW'(1) << (SW - wl)) - SW'(1));
        exp_l = slot_w[2*int'(cfg_rx_pair)] & mask;
        exp_r = slot_w[2*int'(cfg_rx_pair)+1] & mask;
        if (bad) begin
            check(vcnt == 0, "R10", "strobe count under error", vcnt, 0);
            check(mism == 0, "R10", "output line under error", first_act, first_exp);
        end else begin
            check(vcnt == 1, "R7", "strobes per frame", vcnt, 1);
            check(cap_l == exp_l, "R6", "left word (R5 alignment)", cap_l, exp_l);
            check(cap_r == exp_r, "R6", "right word (R4 delay)", cap_r, exp_r);
            check(mism == 0, "R8", "output bits (R9 zero fill)", first_act, first_exp);
        end
    endtask

    task automatic apply(input int ch, input int fc, input int dc, input int wl,
                         input int rp, input int tp, input bit bi, input bit fi);
        logic sdo;
        bit bad;
        @(negedge clk);
        cfg_chans = 2'(ch); cfg_frame_len = 3'(fc); cfg_msb_dly = 2'(dc);
        cfg_wlen = 5'(wl); cfg_rx_pair = 2'(rp); cfg_tx_pair = 2'(tp);
        cfg_bclk_inv = bi; cfg_frm_inv = fi;
        bclk_in = 1'b1 ^ bi; lrclk_in = 1'b1 ^ fi;
        @(negedge clk);
        bad = cfg_bad(ch, fc, dc, wl, rp, tp);
        check(cfg_err == bad, "R10", "error flag", cfg_err, bad);
        for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b0, sdo);
        run_frame(bad);
        run_frame(bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_valid == 0, "R1", "reset strobe", rx_valid, 0);
        check(rx_left == 0 && rx_right == 0, "R1", "reset words", rx_left, 0);
        check(sdata_out == 0, "R1", "reset line", sdata_out, 0);
        // R2 R3 R4: I2S-style stereo, 64-clock frame, 24-bit words
        apply(0, 2, 1, 24, 0, 0, 0, 0);
        // R4: left-justified stereo, 32-clock frame, 16-bit words
        apply(0, 0, 0, 16, 0, 0, 0, 0);
        // R3 R6: 4 slots, receive second pair, send first pair
        apply(1, 3, 0, 24, 1, 0, 0, 0);
        // R4 R7: 8 slots, 8-bit delay fills 32-clock slot exactly, last pair
        apply(2, 4, 2, 24, 3, 2, 0, 0);
        // R3: 48-clock frame, 4 slots of 12 cannot hold 16 bits
        apply(1, 1, 0, 16, 0, 0, 0, 0);
        // R10: 8-slot 64-clock frame too tight; pair out of range
        apply(2, 2, 0, 16, 0, 0, 0, 0);
        apply(1, 3, 0, 16, 2, 0, 0, 0);
        // R10: one bit too tight (1 + 16 > 16)
        apply(0, 0, 1, 16, 0, 0, 0, 0);
        // R2: both clock polarities inverted, 48-clock stereo, 20 bits
        apply(0, 1, 1, 20, 0, 0, 1, 1);
        // R5 R8: random configurations
        for (int r = 0; r < 8; r++) begin
            int ch = $urandom_range(0, 2);
            apply(ch, $urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(16, 24),
                  $urandom_range(0, (1 << ch) - 1), $urandom_range(0, (1 << ch) - 1),
                  1'($urandom), 1'($urandom));
        end
        done = 1;
        report();
    end
endmodule